// File: doc/BRIEF.md
# Scan Register Bank

A row of state flip-flops that normally act as a plain parallel register, but that a tester can turn into one serial shift chain. When the chain is formed, values are pushed in at one end and the old contents come out at the other end. This lets the tester set any internal state and read any internal state through two serial pins. Everything runs on one system clock. The scan clock is modelled as an enable, so there is no second clock domain.

Two control inputs select one of three modes:

- **Run mode** (`scan_en` low, `run_en` high): each cell loads its functional next-state bit.
- **Shift mode** (`scan_en` high): the cells form a chain from `scan_in` toward `scan_out`. Shifting is destructive: the bits that enter replace the stored state.
- **Capture mode** (both enables low): each cell samples the observed result of the logic around it, so that the result can be shifted out afterwards.

The chain length is a parameter. Lengths from 4 to 64 cells are supported.

Top module: `scan_reg_bank`

## Requirements
- R1: A synchronous active-high `rst` clears every cell. One clock after reset is sampled, `q_o` is all zeros and `scan_out` is 0.
- R2: With `scan_en` = 0 and `run_en` = 1 (run mode), cell i loads `run_d[i]` on the next clock.
- R3: With `scan_en` = 1 (shift mode), cell 0 loads `scan_in` and cell i loads the old value of cell i-1. The chain moves exactly one position per clock.
- R4: With `scan_en` = 0 and `run_en` = 0 (capture mode), cell i loads `cap_d[i]` on the next clock.
- R5: When `scan_en` = 1 and `run_en` = 1 together, the bank shifts exactly as in R3, and `run_d` has no effect.
- R6: `scan_out` always shows the last cell (index CHAIN_LEN-1). Sample it before each of CHAIN_LEN consecutive shift clocks: the samples give the contents held before shifting, bit CHAIN_LEN-1 first, down to bit 0.
- R7: After CHAIN_LEN shift clocks, the contents are fully replaced by the serial word. The first bit shifted in ends in cell CHAIN_LEN-1, and the last bit shifted in ends in cell 0.
- R8: While `scan_en` = 0, `scan_in` has no effect on the run or capture result.
- R9: In run mode `cap_d` has no effect. In capture mode `run_d` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Shift enable; has priority over `run_en` |
| run_en | input | 1 | Functional load enable, used when `scan_en` is low |
| scan_in | input | 1 | Serial input to cell 0 |
| run_d | input | CHAIN_LEN | Functional next-state bits |
| cap_d | input | CHAIN_LEN | Observed result bits, sampled in capture mode |
| q_o | output | CHAIN_LEN | Parallel contents of the bank |
| scan_out | output | 1 | Serial output taken from the last cell |

## Verification
A wrong cell value appears on `q_o` one clock after the load that produced it. The same value also reaches `scan_out` within at most CHAIN_LEN-1 further shift clocks.

A broken link in the chain shows up in two ways: as a misplaced or repeated bit in the serial stream read out, and as a parallel word that differs from the word shifted in after CHAIN_LEN clocks. A wrong mode decode shows as the wrong source being loaded. The bench separates the sources by driving different values on `run_d`, `cap_d` and `scan_in` at the same time.

// File: rtl/scan_bank_pkg.sv
package scan_bank_pkg;

    localparam int MIN_LEN = 4;
    localparam int MAX_LEN = 64;

    typedef enum logic [1:0] {
        MODE_CAPTURE = 2'd0,
        MODE_RUN     = 2'd1,
        MODE_SHIFT   = 2'd2
    } bank_mode_e;

    typedef struct packed {
        logic run_bit;
        logic cap_bit;
        logic chain_bit;
    } cell_src_t;

    // Scan wins over the functional load when both enables are high.
    function automatic bank_mode_e pick_mode(input logic scan_en, input logic run_en);
        if (scan_en) begin
            return MODE_SHIFT;
        end else if (run_en) begin
            return MODE_RUN;
        end
        return MODE_CAPTURE;
    endfunction

endpackage

// File: rtl/scan_mode_ctl.sv
module scan_mode_ctl
    import scan_bank_pkg::*;
(
    input  logic       scan_en,
    input  logic       run_en,
    output bank_mode_e mode
);

    always_comb begin
        mode = pick_mode(scan_en, run_en);
    end

endmodule

// File: rtl/scan_bank_cell.sv
module scan_bank_cell
    import scan_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bank_mode_e mode,
    input  cell_src_t  src,
    output logic       q
);

    logic q_next;

    always_comb begin
        unique case (mode)
            MODE_SHIFT: q_next = src.chain_bit;
            MODE_RUN:   q_next = src.run_bit;
            default:    q_next = src.cap_bit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/scan_reg_bank.sv
module scan_reg_bank
    import scan_bank_pkg::*;
#(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scan_en,
    input  logic                 run_en,
    input  logic                 scan_in,
    input  logic [CHAIN_LEN-1:0] run_d,
    input  logic [CHAIN_LEN-1:0] cap_d,
    output logic [CHAIN_LEN-1:0] q_o,
    output logic                 scan_out
);

    localparam int LAST = CHAIN_LEN - 1;

    bank_mode_e             mode;
    logic [CHAIN_LEN-1:0]   cell_q;
    cell_src_t              src [CHAIN_LEN];

    scan_mode_ctl u_ctl (
        .scan_en (scan_en),
        .run_en  (run_en),
        .mode    (mode)
    );

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
        if (i == 0) begin : g_head
            assign src[i].chain_bit = scan_in;
        end else begin : g_link
            assign src[i].chain_bit = cell_q[i-1];
        end
        assign src[i].run_bit = run_d[i];
        assign src[i].cap_bit = cap_d[i];

        scan_bank_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .src  (src[i]),
            .q    (cell_q[i])
        );
    end

    assign q_o      = cell_q;
    assign scan_out = cell_q[LAST];

    // Reset state
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (q_o == '0 && scan_out == 1'b0));

    // Run mode loads the functional word
    assert_run_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && run_en) |=> q_o == $past(run_d));

    // Shift by one; also covers scan priority over run_en (R5)
    assert_shift_step_R3: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> q_o == {$past(q_o[LAST-1:0]), $past(scan_in)});

    // Capture mode samples the observed word
    assert_capture_load_R4: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && !run_en) |=> q_o == $past(cap_d));

    // Serial output follows the neighbour of the last cell after a shift
    assert_scan_out_step_R6: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> scan_out == $past(q_o[LAST-1]));

endmodule

// File: tb/scan_reg_bank_test.sv
module scan_reg_bank_test;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         scan_en = 1'b0;
    logic         run_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] run_d = '0;
    logic [N-1:0] cap_d = '0;
    logic [N-1:0] q_o;
    logic         scan_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    scan_reg_bank #(.CHAIN_LEN(N)) uut (
        .clk      (clk),
        .rst      (rst),
        .scan_en  (scan_en),
        .run_en   (run_en),
        .scan_in  (scan_in),
        .run_d    (run_d),
        .cap_d    (cap_d),
        .q_o      (q_o),
        .scan_out (scan_out)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic [N-1:0] c;

        // R1: reset state
        tick(); tick(); tick();
        check("R1 q_o", q_o, '0);
        check("R1 scan_out", {{(N-1){1'b0}}, scan_out}, '0);
        rst = 1'b0;

        for (int v = 0; v < (1 << N); v++) begin
            a = N'(v);
            b = N'((v * 37 + 11) & ((1 << N) - 1));

            // R2/R8/R9: run load with conflicting cap_d and scan_in
            scan_en = 1'b0; run_en = 1'b1;
            run_d = a; cap_d = ~a; scan_in = ~a[0];
            tick();
            check("R2 run load", q_o, a);

            // R3/R5/R6: shift b in while reading a out
            for (int k = 0; k < N; k++) begin
                check("R6 scan_out order", {{(N-1){1'b0}}, scan_out},
                      {{(N-1){1'b0}}, a[N-1-k]});
                scan_en = 1'b1;
                run_en  = k[0];            // R5: odd steps also raise run_en
                run_d   = ~b;
                cap_d   = b ^ a;
                scan_in = b[N-1-k];
                tick();
                if (k == 0) begin
                    check("R3 one step", q_o, {a[N-2:0], b[N-1]});
                end
            end
            // R7: contents fully replaced
            check("R7 replaced", q_o, b);
        end

        // R4/R8/R9: capture sweep
        for (int v = 0; v < (1 << N); v++) begin
            c = N'(v);
            scan_en = 1'b0; run_en = 1'b0;
            cap_d = c; run_d = ~c; scan_in = c[3];
            tick();
            check("R4 capture", q_o, c);
        end

        // R5: both enables, explicit priority
        scan_en = 1'b0; run_en = 1'b1; run_d = 8'hA5; tick();
        check("R2 preload", q_o, 8'hA5);
        scan_en = 1'b1; run_en = 1'b1; run_d = 8'h00; cap_d = 8'hFF; scan_in = 1'b1;
        tick();
        check("R5 scan priority", q_o, 8'h4B);

        // R8: scan_in toggling in run mode does nothing
        scan_en = 1'b0; run_en = 1'b1; run_d = 8'h3C; scan_in = 1'b1;
        tick();
        scan_in = 1'b0;
        tick();
        check("R8 run ignores scan_in", q_o, 8'h3C);

        // R1: reset in mid-operation
        run_d = 8'hFF; tick();
        check("R2 all ones", q_o, 8'hFF);
        rst = 1'b1; tick();
        check("R1 mid reset", q_o, '0);
        check("R1 mid reset scan_out", {{(N-1){1'b0}}, scan_out}, '0);
        rst = 1'b0; scan_en = 1'b0; run_en = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule